// File: doc/BRIEF.md
# Parallel Flash Query and Identifier Read Formatter

This block produces the read data that a flash bank returns while it sits in query mode or identifier mode. The bank is modelled as several identical devices wired side by side on one data bus. From the byte address of a read, the bank width, the width each device is used at, and that device's widest native width, the block finds the table index the devices would see. It then takes either a byte of the parameter-query table or one of the identifier words, and spreads the per-device answer over every device lane of the bus. A read wider than the bank is built from several consecutive bank-wide lookups. A legacy variant, chosen when the device width parameter is zero, keeps a simpler indexing scheme for older systems.

The surrounding command decoder decides when a read belongs to query or identifier mode. It presents the address, the mode and the access size with a one-cycle strobe. The formatted word appears on the next clock edge together with a one-cycle valid pulse. Widths are fixed by parameters, so one instance serves one bank organisation.

Top module: `fq_resp_fmt`

## Requirements
- R1: In the non-legacy variant, the table index is the byte address shifted right by log2(BANK_W) + log2(native width) - log2(DEV_W).
- R2: A query index at or beyond the table depth (QT_DEPTH, default 82) yields zero for that device.
- R3: When DEV_W is smaller than the native width, a query byte is repeated across the native width rather than zero-padded. Only DEV_W = 1 is supported in that case; any other mismatch yields zero query data.
- R4: In the non-legacy variant, the per-device answer, DEV_W bytes wide with the table byte in its lowest byte, is copied into every DEV_W-byte lane of the bank.
- R5: In identifier mode (rd_mode = 1), the index taken modulo 256 selects MFR_ID at 0 and DEVICE_ID at 1, each truncated to DEV_W bytes. Every other index gives zero.
- R6: An access wider than the bank is assembled from bank-wide slices. The slice starting at byte i is looked up at address rd_addr + i*BANK_W.
- R7: In the legacy variant (DEV_W = 0), the index is the low address byte shifted right by log2(BANK_W). A query returns the table byte zero-extended. Identifier index 0 returns {LID0,LID1} and index 1 returns {LID2,LID3} in the low 16 bits.
- R8: Table entries 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59 ("QRY"), and entry 0x13 holds 0x01.
- R9: rsp_valid is high exactly in the cycle after a cycle with rd_stb high. rsp_data is loaded only then and holds its value otherwise.
- R10: During and right after reset, rsp_valid is 0 and rsp_data is 0.
- R11: rd_size encodes the access as 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Bytes of rsp_data at or above the access size are zero. An access narrower than the bank returns the low bytes of the bank-wide answer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One-cycle read request |
| rd_mode | input | 1 | 0 = parameter query, 1 = identifier read |
| rd_addr | input | ADDR_W | Byte address of the read within the bank |
| rd_size | input | 2 | Access size code (see R11) |
| rsp_valid | output | 1 | Pulses one cycle after rd_stb |
| rsp_data | output | 32 | Formatted response word |

## Verification
Two functions meet in one cycle in a wide access on a narrow bank. The slice lookup at the shifted address (R6) and the lane copying (R4) act on the same word, together with the byte masking of the access size (R11). The bench provokes this with a four-byte query on a two-byte bank made of byte devices. The expected word is then two copies of "Q" below two copies of "Y", and a wrong slice offset or a wrong lane copy shows up as a different byte pattern. Identifier reads of four bytes on the bank with narrow devices in wide packages also mix the modulo-256 selection with slice assembly, and are judged byte by byte against values worked out by hand.

// File: rtl/flashq_pkg.sv
package flashq_pkg;

   localparam int RSP_BYTES = 4;
   localparam int RSP_W     = 8 * RSP_BYTES;

   typedef enum logic {
      MODE_QUERY = 1'b0,
      MODE_IDENT = 1'b1
   } qmode_e;

   // Access size code to byte count; code 3 is treated as a full word.
   function automatic int size_to_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 2;
         default: return 4;
      endcase
   endfunction

   function automatic logic legal_width(input int w);
      return (w == 1) || (w == 2) || (w == 4);
   endfunction

endpackage

// File: rtl/fq_qtab.sv
// Parameter-query table of one device, computed from the bank geometry.
module fq_qtab #(
   parameter int ADDR_W       = 24,
   parameter int DEPTH        = 82,
   parameter int DEV_LEN_LOG2 = 16,
   parameter int BLK_PER_DEV  = 64,
   parameter int SECT_PER_DEV = 1024,
   parameter int WBUF_LOG2    = 11
) (
   input  logic [ADDR_W-1:0] idx,
   output logic [7:0]        byte_o
);

   localparam logic [15:0] BLK_M1 = 16'(BLK_PER_DEV - 1);
   localparam logic [23:0] SECT_V = 24'(SECT_PER_DEV);

   logic in_range;
   logic [7:0] entry;

   assign in_range = (idx < ADDR_W'(DEPTH));

   always_comb begin
      case (idx[7:0])
         8'h10:   entry = 8'h51;
         8'h11:   entry = 8'h52;
         8'h12:   entry = 8'h59;
         8'h13:   entry = 8'h01;
         8'h15:   entry = 8'h31;
         8'h1B:   entry = 8'h45;
         8'h1C:   entry = 8'h55;
         8'h1F:   entry = 8'h07;
         8'h20:   entry = 8'h07;
         8'h21:   entry = 8'h0A;
         8'h23:   entry = 8'h04;
         8'h24:   entry = 8'h04;
         8'h25:   entry = 8'h04;
         8'h27:   entry = 8'(DEV_LEN_LOG2);
         8'h28:   entry = 8'h02;
         8'h2A:   entry = 8'(WBUF_LOG2);
         8'h2C:   entry = 8'h01;
         8'h2D:   entry = BLK_M1[7:0];
         8'h2E:   entry = BLK_M1[15:8];
         8'h2F:   entry = SECT_V[15:8];
         8'h30:   entry = SECT_V[23:16];
         8'h31:   entry = 8'h50;
         8'h32:   entry = 8'h52;
         8'h33:   entry = 8'h49;
         8'h34:   entry = 8'h31;
         8'h35:   entry = 8'h30;
         8'h3F:   entry = 8'h01;
         default: entry = 8'h00;
      endcase
   end

   assign byte_o = in_range ? entry : 8'h00;

endmodule

// File: rtl/fq_lane.sv
// One bank-wide slice: index computation, table/identifier pick, lane copy.
module fq_lane #(
   parameter int          ADDR_W       = 24,
   parameter int          BANK_B       = 4,
   parameter int          DEV_B        = 2,
   parameter int          NATIVE_B     = 2,
   parameter int          DEPTH        = 82,
   parameter int          DEV_LEN_LOG2 = 16,
   parameter int          BLK_PER_DEV  = 64,
   parameter int          SECT_PER_DEV = 1024,
   parameter int          WBUF_LOG2    = 11,
   parameter logic [15:0] MFR_ID       = 16'h0089,
   parameter logic [15:0] DEVICE_ID    = 16'h0018
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                mode,
   output logic [8*BANK_B-1:0] lane_o
);
   import flashq_pkg::*;

   localparam int SHIFT     = $clog2(BANK_B) + $clog2(NATIVE_B) - $clog2(DEV_B);
   localparam bit NARROW    = (DEV_B < NATIVE_B);
   localparam bit SUPPORTED = !NARROW || ((DEV_B == 1) && (BANK_B <= 4));
   localparam int COPIES    = BANK_B / DEV_B;

   logic [ADDR_W-1:0]     boff;
   logic [7:0]            qbyte;
   logic [8*NATIVE_B-1:0] native_word;
   logic [8*DEV_B-1:0]    dev_q;
   logic [31:0]           id_word;
   logic [8*DEV_B-1:0]    dev_r;

   assign boff = addr >> SHIFT;

   fq_qtab #(
      .ADDR_W       (ADDR_W),
      .DEPTH        (DEPTH),
      .DEV_LEN_LOG2 (DEV_LEN_LOG2),
      .BLK_PER_DEV  (BLK_PER_DEV),
      .SECT_PER_DEV (SECT_PER_DEV),
      .WBUF_LOG2    (WBUF_LOG2)
   ) u_qtab (
      .idx    (boff),
      .byte_o (qbyte)
   );

   // Narrow use of a wide package repeats the byte over the native width.
   assign native_word = {NATIVE_B{qbyte}};

   generate
      if (!SUPPORTED) begin : g_unsup
         assign dev_q = '0;
      end else if (NARROW) begin : g_narrow
         assign dev_q = native_word[8*DEV_B-1:0];
      end else begin : g_native
         assign dev_q = (8*DEV_B)'(qbyte);
      end
   endgenerate

   always_comb begin
      case (boff[7:0])
         8'h00:   id_word = {16'h0000, MFR_ID};
         8'h01:   id_word = {16'h0000, DEVICE_ID};
         default: id_word = 32'h0000_0000;
      endcase
   end

   assign dev_r  = (qmode_e'(mode) == MODE_IDENT) ? id_word[8*DEV_B-1:0] : dev_q;
   assign lane_o = {COPIES{dev_r}};

endmodule

// File: rtl/fq_legacy.sv
// Older indexing scheme used when no device width is configured.
module fq_legacy #(
   parameter int         ADDR_W       = 24,
   parameter int         BANK_B       = 2,
   parameter int         DEPTH        = 82,
   parameter int         DEV_LEN_LOG2 = 16,
   parameter int         BLK_PER_DEV  = 64,
   parameter int         SECT_PER_DEV = 1024,
   parameter int         WBUF_LOG2    = 11,
   parameter logic [7:0] LID0         = 8'h00,
   parameter logic [7:0] LID1         = 8'h00,
   parameter logic [7:0] LID2         = 8'h00,
   parameter logic [7:0] LID3         = 8'h00
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       mode,
   output logic [flashq_pkg::RSP_W-1:0] word_o
);
   import flashq_pkg::*;

   localparam int LSH = $clog2(BANK_B);

   logic [ADDR_W-1:0] low_byte;
   logic [ADDR_W-1:0] boff;
   logic [7:0]        qbyte;
   logic [RSP_W-1:0]  id_word;

   assign low_byte = addr & ADDR_W'(255);
   assign boff     = low_byte >> LSH;

   fq_qtab #(
      .ADDR_W       (ADDR_W),
      .DEPTH        (DEPTH),
      .DEV_LEN_LOG2 (DEV_LEN_LOG2),
      .BLK_PER_DEV  (BLK_PER_DEV),
      .SECT_PER_DEV (SECT_PER_DEV),
      .WBUF_LOG2    (WBUF_LOG2)
   ) u_qtab (
      .idx    (boff),
      .byte_o (qbyte)
   );

   always_comb begin
      case (boff[7:0])
         8'h00:   id_word = {16'h0000, LID0, LID1};
         8'h01:   id_word = {16'h0000, LID2, LID3};
         default: id_word = '0;
      endcase
   end

   assign word_o = (qmode_e'(mode) == MODE_IDENT) ? id_word : RSP_W'(qbyte);

endmodule

// File: rtl/fq_resp_fmt.sv
module fq_resp_fmt #(
   parameter int          ADDR_W     = 24,
   parameter int          BANK_W     = 4,
   parameter int          DEV_W      = 2,
   parameter int          MAX_DEV_W  = 0,
   parameter int          QT_DEPTH   = 82,
   parameter int          NUM_BLOCKS = 64,
   parameter int          SECTOR_LEN = 65536,
   parameter logic [15:0] MFR_ID     = 16'h0089,
   parameter logic [15:0] DEVICE_ID  = 16'h0018,
   parameter logic [7:0]  LID0       = 8'h00,
   parameter logic [7:0]  LID1       = 8'h89,
   parameter logic [7:0]  LID2       = 8'h00,
   parameter logic [7:0]  LID3       = 8'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              rd_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [1:0]        rd_size,
   output logic              rsp_valid,
   output logic [31:0]       rsp_data
);
   import flashq_pkg::*;

   localparam bit LEGACY       = (DEV_W == 0);
   localparam int NATIVE_W     = (MAX_DEV_W == 0) ? DEV_W : MAX_DEV_W;
   localparam int NDEV         = LEGACY ? 1 : BANK_W / ((DEV_W == 0) ? 1 : DEV_W);
   localparam int SECT_PER_DEV = SECTOR_LEN / NDEV;
   localparam int DEV_LEN_LOG2 = $clog2(SECT_PER_DEV * NUM_BLOCKS);
   localparam int WBUF_LOG2    = (BANK_W == 1) ? 8 : 11;
   localparam int NSLICE       = RSP_BYTES / BANK_W;

   // Elaboration checks on the configuration.
   if (!legal_width(BANK_W)) begin : g_bad_bank
      $error("fq_resp_fmt: BANK_W must be 1, 2 or 4");
   end
   if (!LEGACY && !legal_width(DEV_W)) begin : g_bad_dev
      $error("fq_resp_fmt: DEV_W must be 0, 1, 2 or 4");
   end
   if (!LEGACY && (DEV_W > BANK_W)) begin : g_dev_gt_bank
      $error("fq_resp_fmt: DEV_W must not exceed BANK_W");
   end
   if (!LEGACY && (!legal_width(NATIVE_W) || (NATIVE_W < DEV_W))) begin : g_bad_native
      $error("fq_resp_fmt: MAX_DEV_W must be 1, 2 or 4 and not below DEV_W");
   end
   if ((QT_DEPTH < 1) || (QT_DEPTH > 256)) begin : g_bad_depth
      $error("fq_resp_fmt: QT_DEPTH must lie in 1..256");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("fq_resp_fmt: ADDR_W must be at least 9");
   end

   logic [RSP_W-1:0] raw_word;
   logic [RSP_W-1:0] masked_word;
   int               acc_bytes;

   generate
      if (LEGACY) begin : g_legacy
         fq_legacy #(
            .ADDR_W       (ADDR_W),
            .BANK_B       (BANK_W),
            .DEPTH        (QT_DEPTH),
            .DEV_LEN_LOG2 (DEV_LEN_LOG2),
            .BLK_PER_DEV  (NUM_BLOCKS),
            .SECT_PER_DEV (SECT_PER_DEV),
            .WBUF_LOG2    (WBUF_LOG2),
            .LID0         (LID0),
            .LID1         (LID1),
            .LID2         (LID2),
            .LID3         (LID3)
         ) u_legacy (
            .addr   (rd_addr),
            .mode   (rd_mode),
            .word_o (raw_word)
         );
      end else begin : g_sliced
         for (genvar s = 0; s < NSLICE; s++) begin : g_slice
            logic [ADDR_W-1:0]   slice_addr;
            logic [8*BANK_W-1:0] slice_data;

            // Slice at byte s*BANK_W looks up address + (s*BANK_W)*BANK_W.
            assign slice_addr = rd_addr + ADDR_W'(s * BANK_W * BANK_W);

            fq_lane #(
               .ADDR_W       (ADDR_W),
               .BANK_B       (BANK_W),
               .DEV_B        (DEV_W),
               .NATIVE_B     (NATIVE_W),
               .DEPTH        (QT_DEPTH),
               .DEV_LEN_LOG2 (DEV_LEN_LOG2),
               .BLK_PER_DEV  (NUM_BLOCKS),
               .SECT_PER_DEV (SECT_PER_DEV),
               .WBUF_LOG2    (WBUF_LOG2),
               .MFR_ID       (MFR_ID),
               .DEVICE_ID    (DEVICE_ID)
            ) u_lane (
               .addr   (slice_addr),
               .mode   (rd_mode),
               .lane_o (slice_data)
            );

            assign raw_word[s*8*BANK_W +: 8*BANK_W] = slice_data;
         end
      end
   endgenerate

   assign acc_bytes = size_to_bytes(rd_size);

   always_comb begin
      for (int j = 0; j < RSP_BYTES; j++) begin
         masked_word[8*j +: 8] = (j < acc_bytes) ? raw_word[8*j +: 8] : 8'h00;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= rd_stb;
         if (rd_stb) begin
            rsp_data <= masked_word;
         end
      end
   end

endmodule

// File: rtl/fq_resp_fmt_chk.sv
module fq_resp_fmt_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rd_stb,
   input logic [1:0]  rd_size,
   input logic        rsp_valid,
   input logic [31:0] rsp_data
);

   // R9
   valid_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> rsp_valid);

   // R9
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> !rsp_valid);

   // R9
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rsp_data));

   // R11
   byte_access_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && (rd_size == 2'd0)) |=> (rsp_data[31:8] == 24'h0));

   // R11
   half_access_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && (rd_size == 2'd1)) |=> (rsp_data[31:16] == 16'h0));

endmodule

bind fq_resp_fmt fq_resp_fmt_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_stb    (rd_stb),
   .rd_size   (rd_size),
   .rsp_valid (rsp_valid),
   .rsp_data  (rsp_data)
);

// File: tb/fq_resp_fmt_bench.sv
module fq_resp_fmt_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_stb = 1'b0;
   logic          rd_mode = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [1:0]    rd_size = 2'd2;

   logic        va, vb, vc, vd, ve, vf;
   logic [31:0] da, db, dc, dd, de, df;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // A: two x16 devices, 4-byte bank
   fq_resp_fmt #(.ADDR_W(AW), .BANK_W(4), .DEV_W(2), .MAX_DEV_W(2),
                 .MFR_ID(16'h0089), .DEVICE_ID(16'h1234)) u_fq_resp_fmt (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_mode(rd_mode),
      .rd_addr(rd_addr), .rd_size(rd_size), .rsp_valid(va), .rsp_data(da));

   // B: four x16 parts used at x8, 4-byte bank
   fq_resp_fmt #(.ADDR_W(AW), .BANK_W(4), .DEV_W(1), .MAX_DEV_W(2),
                 .MFR_ID(16'h0089), .DEVICE_ID(16'h1234)) u_fq_resp_fmt_b (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_mode(rd_mode),
      .rd_addr(rd_addr), .rd_size(rd_size), .rsp_valid(vb), .rsp_data(db));

   // C: one byte-wide device
   fq_resp_fmt #(.ADDR_W(AW), .BANK_W(1), .DEV_W(1), .MAX_DEV_W(1),
                 .MFR_ID(16'h0089), .DEVICE_ID(16'h1234)) u_fq_resp_fmt_c (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_mode(rd_mode),
      .rd_addr(rd_addr), .rd_size(rd_size), .rsp_valid(vc), .rsp_data(dc));

   // D: x32 part used at x16 (unsupported narrowing)
   fq_resp_fmt #(.ADDR_W(AW), .BANK_W(2), .DEV_W(2), .MAX_DEV_W(4),
                 .MFR_ID(16'h0089), .DEVICE_ID(16'h1234)) u_fq_resp_fmt_d (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_mode(rd_mode),
      .rd_addr(rd_addr), .rd_size(rd_size), .rsp_valid(vd), .rsp_data(dd));

   // E: legacy, 2-byte bank
   fq_resp_fmt #(.ADDR_W(AW), .BANK_W(2), .DEV_W(0), .MAX_DEV_W(0),
                 .LID0(8'h01), .LID1(8'h02), .LID2(8'h03), .LID3(8'h04)) u_fq_resp_fmt_e (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_mode(rd_mode),
      .rd_addr(rd_addr), .rd_size(rd_size), .rsp_valid(ve), .rsp_data(de));

   // F: two byte devices, 2-byte bank
   fq_resp_fmt #(.ADDR_W(AW), .BANK_W(2), .DEV_W(1), .MAX_DEV_W(1),
                 .MFR_ID(16'h0089), .DEVICE_ID(16'h1234)) u_fq_resp_fmt_f (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_mode(rd_mode),
      .rd_addr(rd_addr), .rd_size(rd_size), .rsp_valid(vf), .rsp_data(df));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Strobe one read; return just after the edge that registers it.
   task automatic do_read(input logic [AW-1:0] a, input logic m, input logic [1:0] sz);
      @(negedge clk);
      rd_addr = a;
      rd_mode = m;
      rd_size = sz;
      rd_stb  = 1'b1;
      @(negedge clk);
      rd_stb  = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10", "valid in reset", {31'b0, va}, 32'h0);
      chk("R10", "data in reset", da, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "valid after reset", {31'b0, vb}, 32'h0);
      chk("R10", "data after reset", db, 32'h0);
   endtask

   task automatic t_index_and_table();
      // A: shift 2; index 0x10..0x13 at 0x40..0x4C
      do_read(24'h40, 1'b0, 2'd2);
      chk("R8", "A idx10 Q", da, 32'h0051_0051);
      do_read(24'h44, 1'b0, 2'd2);
      chk("R8", "A idx11 R", da, 32'h0052_0052);
      do_read(24'h48, 1'b0, 2'd2);
      chk("R1", "A idx12 Y", da, 32'h0059_0059);
      do_read(24'h4C, 1'b0, 2'd2);
      chk("R8", "A idx13", da, 32'h0001_0001);
      // wrong shift would land on index 0x20 -> not 'Q'
      do_read(24'h20, 1'b0, 2'd2);
      chk("R1", "A addr 0x20 is idx 8", da, 32'h0);
   endtask

   task automatic t_range();
      do_read(24'h148, 1'b0, 2'd2);
      chk("R2", "A idx 0x52 zero", da, 32'h0);
      do_read(24'hC4, 1'b0, 2'd2);
      chk("R2", "A idx 0x31 in range", da, 32'h0050_0050);
   endtask

   task automatic t_narrow();
      do_read(24'h80, 1'b0, 2'd2);
      chk("R3", "B x8 repeat Q", db, 32'h5151_5151);
      chk("R3", "D unsupported narrowing", dd, 32'h0);
   endtask

   task automatic t_replicate();
      do_read(24'h0, 1'b1, 2'd2);
      chk("R4", "A id lanes", da, 32'h0089_0089);
      chk("R4", "B id lanes", db, 32'h8989_8989);
   endtask

   task automatic t_ident();
      do_read(24'h4, 1'b1, 2'd2);
      chk("R5", "A device id", da, 32'h1234_1234);
      do_read(24'h8, 1'b1, 2'd2);
      chk("R5", "A idx2 zero", da, 32'h0);
      chk("R5", "B device id", db, 32'h3434_3434);
      do_read(24'h400, 1'b1, 2'd2);
      chk("R5", "A idx 0x100 wraps", da, 32'h0089_0089);
   endtask

   task automatic t_wide();
      do_read(24'h10, 1'b0, 2'd2);
      chk("R6", "C four slices QRY", dc, 32'h0159_5251);
      do_read(24'h20, 1'b0, 2'd2);
      chk("R6", "F slice at +4", df, 32'h5959_5151);
      do_read(24'h0, 1'b1, 2'd2);
      chk("R6", "D id two slices", dd, 32'h1234_0089);
      chk("R6", "C id four slices", dc, 32'h0000_3489);
   endtask

   task automatic t_legacy();
      do_read(24'h20, 1'b0, 2'd2);
      chk("R7", "E query idx10", de, 32'h0000_0051);
      do_read(24'h120, 1'b0, 2'd2);
      chk("R7", "E low byte only", de, 32'h0000_0051);
      do_read(24'hA4, 1'b0, 2'd2);
      chk("R7", "E idx 0x52 zero", de, 32'h0);
      do_read(24'h0, 1'b1, 2'd2);
      chk("R7", "E id0", de, 32'h0000_0102);
      do_read(24'h202, 1'b1, 2'd2);
      chk("R7", "E id1", de, 32'h0000_0304);
   endtask

   task automatic t_size();
      do_read(24'h10, 1'b0, 2'd1);
      chk("R11", "C half access", dc, 32'h0000_5251);
      do_read(24'h20, 1'b0, 2'd0);
      chk("R11", "F byte access", df, 32'h0000_0051);
      do_read(24'h40, 1'b0, 2'd3);
      chk("R11", "A code 3 full", da, 32'h0051_0051);
      do_read(24'h80, 1'b0, 2'd1);
      chk("R11", "B half of bank", db, 32'h0000_5151);
   endtask

   task automatic t_timing();
      do_read(24'h4, 1'b1, 2'd2);
      chk("R9", "valid pulse", {31'b0, va}, 32'h1);
      // change inputs without a strobe; output must hold
      @(negedge clk);
      rd_addr = 24'h0;
      @(negedge clk);
      chk("R9", "valid drops", {31'b0, va}, 32'h0);
      chk("R9", "data holds", da, 32'h1234_1234);
   endtask

   initial begin
      t_reset();
      t_index_and_table();
      t_range();
      t_narrow();
      t_replicate();
      t_ident();
      t_wide();
      t_legacy();
      t_size();
      t_timing();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule